// File: doc/BRIEF.md
# Sequential Two's Complement Multiplier

This block forms the signed product of two two's complement operands of `WIDTH` bits, one multiplier bit per clock cycle. A single-cycle pulse on `start_i` while the block is idle captures both operands and clears the accumulator. On every following cycle the rightmost remaining multiplier bit selects either zero or the sign-extended multiplicand. That value is added into the upper half of a `2*WIDTH`-bit accumulator by an adder/subtracter that is `WIDTH+1` bits wide. The accumulator and the multiplier register then both shift right by one bit.

The multiplier's most significant bit carries weight `-2^(WIDTH-1)`. Its partial product is therefore subtracted on the final step, using operand inversion and carry-in, and the operand is never negated up front. The final step also performs the last arithmetic right shift. After `WIDTH` steps the full product sits right-aligned on `product_o` and `done_o` pulses for one cycle. The product stays on `product_o` until the next accepted start.

Top module: `seq_twos_mult`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A `start_i` sampled high while `busy_o` is 0 captures `mcand_i` and `mplier_i`, and `busy_o` is 1 from the next cycle on.
- R3: `busy_o` stays high for exactly `WIDTH` cycles. `done_o` is then high for exactly one cycle, in the cycle after `busy_o` falls.
- R4: For two non-negative operands, `product_o` during `done_o` equals their product as a `2*WIDTH`-bit value.
- R5: A negative multiplicand paired with a non-negative multiplier gives the correct signed product, through sign extension of the multiplicand into the wider adder.
- R6: A negative multiplier gives the correct signed product, through subtraction of the sign-bit partial product on the last step.
- R7: When both operands equal `-2^(WIDTH-1)`, the product equals `+2^(2*WIDTH-2)`.
- R8: A `start_i` that arrives while `busy_o` is 1 has no effect. Busy timing, the done cycle and the product all belong to the operation already running.
- R9: While idle and with no start, `product_o` holds the last result unchanged.
- R10: `busy_o` and `done_o` are never high in the same cycle.
- R11: A start in the cycle where `done_o` is high is accepted at once, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication when idle |
| mcand_i | input | WIDTH | Multiplicand, two's complement |
| mplier_i | input | WIDTH | Multiplier, two's complement |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle pulse, product valid |
| product_o | output | 2*WIDTH | Signed product, right-aligned |

## Verification
For a start accepted at a clock edge, `busy_o` rises right after that edge and stays high for `WIDTH` cycles. `done_o` and the final product appear right after the `WIDTH`-th following edge. The bench's reference model advances on the same edges with a plain countdown and a product computed by ordinary multiplication. All outputs are compared at the falling edge, so each registered result is sampled half a cycle after the edge that produced it. `product_o` is compared only while the model is idle, because the accumulator holds partial sums during the run. The bench also covers a start in the done cycle and a start injected mid-run.

// File: rtl/mult_pkg.sv
package mult_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mult_state_e;
endpackage

// File: rtl/mult_addsub.sv
module mult_addsub #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = WIDTH + 1
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic          sub_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] b_eff;
  logic [AW:0]   carry;

  assign b_eff    = b_i ^ {AW{sub_i}};
  assign carry[0] = sub_i;

  for (genvar k = 0; k < AW; k++) begin : g_bit
    assign sum_o[k]   = a_i[k] ^ b_eff[k] ^ carry[k];
    assign carry[k+1] = (a_i[k] & b_eff[k]) | (carry[k] & (a_i[k] ^ b_eff[k]));
  end
endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  mult_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == CNT_W'(WIDTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (last_o) begin
        state_q <= ST_IDLE;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = WIDTH + 1,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [PW-1:0]    acc_o
);
  logic [WIDTH-1:0] mcand_q, mplier_q;
  logic [PW-1:0]    acc_q;
  logic [AW-1:0]    hi_ext, pp, sum;

  // sign-extend both adder inputs by one bit
  assign hi_ext = {acc_q[PW-1], acc_q[PW-1:WIDTH]};
  assign pp     = {mcand_q[WIDTH-1], mcand_q} & {AW{mplier_q[0]}};

  mult_addsub #(.WIDTH(WIDTH)) addsub_i (
    .a_i   (hi_ext),
    .b_i   (pp),
    .sub_i (last_i),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
      acc_q    <= '0;
    end else if (step_i) begin
      mplier_q <= mplier_q >> 1;
      // add then arithmetic shift: sum's sign bit lands on top
      acc_q    <= {sum, acc_q[WIDTH-1:1]};
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/seq_twos_mult.sv
module seq_twos_mult #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PW-1:0]    product_o
);
  logic load, step, last;

  mult_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  mult_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .last_i   (last),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .acc_o    (product_o)
  );
endmodule

// File: rtl/seq_twos_mult_chk.sv
module seq_twos_mult_chk #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = 2 * WIDTH
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [PW-1:0] product_o
);
  logic [15:0] run_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_len_q <= '0;
    else if (busy_o) run_len_q <= run_len_q + 1'b1;
    else run_len_q <= '0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R3
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_len_q == 16'(WIDTH)));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));

  // R10
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

bind seq_twos_mult seq_twos_mult_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/seq_twos_mult_tb_top.sv
module seq_twos_mult_tb_top;
  localparam int W = 8;
  localparam int PW = 2 * W;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0, mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string op_tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_twos_mult #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  // reference model state
  logic          m_busy = 0, m_done = 0;
  int            m_left = 0;
  logic [PW-1:0] m_prod = '0, m_pend = '0;
  string         m_tag = "R4", m_pend_tag = "R4";

  function automatic logic [PW-1:0] smul(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [PW-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (!m_busy && start) begin
        m_busy = 1; m_left = W;
        m_pend = smul(mcand, mplier); m_pend_tag = op_tag;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_prod = m_pend; m_tag = m_pend_tag;
        end
      end
    end
  end

  task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", PW'(busy), PW'(m_busy));
      chk("R3", PW'(done), PW'(m_done));
      chk("R10", PW'(busy && done), '0);
      if (!m_busy) chk(m_done ? m_tag : "R9", product, m_prod);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, string tag);
    mcand = a; mplier = b; op_tag = tag; start = 1;
    @(negedge clk); start = 0;
    repeat (W) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", PW'(busy), '0);
    chk("R1", PW'(done), '0);
    chk("R1", product, '0);
    rst_n = 1;
    idle(2);
    run_op(8'd7, 8'd9, "R4");          idle(2);
    run_op(8'd127, 8'd127, "R4");      idle(1);
    run_op(8'd0, 8'd55, "R4");         idle(1);
    run_op(-8'sd5, 8'd6, "R5");        idle(1);
    run_op(-8'sd128, 8'd127, "R5");    idle(1);
    run_op(8'd6, -8'sd5, "R6");        idle(1);
    run_op(-8'sd3, -8'sd1, "R6");      idle(1);
    run_op(8'd127, -8'sd128, "R6");    idle(1);
    run_op(-8'sd128, -8'sd128, "R7");  idle(3);
    // R8: start mid-run with other operands is ignored
    mcand = 8'd11; mplier = -8'sd13; op_tag = "R8"; start = 1;
    @(negedge clk); start = 0;
    idle(2);
    mcand = 8'd99; mplier = 8'd99; start = 1;
    @(negedge clk); start = 0;
    repeat (W - 3) @(negedge clk);
    idle(2);
    // R11: back-to-back, new start in the done cycle
    run_op(8'd21, -8'sd4, "R11");
    run_op(-8'sd100, 8'd3, "R11");
    run_op(8'd1, -8'sd1, "R11");
    idle(3);
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      run_op(a, b, b[W-1] ? "R6" : (a[W-1] ? "R5" : "R4"));
      if (i % 3 == 0) idle(1 + i % 4);
    end
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule